// File: doc/BRIEF.md
# Serial Bit Gather/Scatter Unit

This block performs three mask-driven permutations of a 64-bit source word: gathering the bits selected by a mask into the low end of the result (extract), spreading the low bits of the source out to the positions selected by a mask (deposit), and splitting the source into its mask-0 and mask-1 bits, each group kept in its original order (centrifuge). Extract and centrifuge are both treated as sorting the source bits by their mask bit. All three share one sequential engine that examines a single mask bit per clock. Every operation therefore takes a fixed WIDTH cycles, which is 64 by default.

The issuing pipeline stage presents an operation on a valid/ready pair. `op_ready` is high exactly when the unit is idle, and an operation is taken on a clock edge where `op_valid` and `op_ready` are both high. There is no queue. A `op_valid` that arrives while the unit is busy is dropped rather than held, so the issuing stage must treat `busy` as its stall signal and re-present the request later. The result side has no back-pressure. `done` pulses for one cycle, and `result` stays unchanged from that cycle until the next operation is accepted.

Top module: `bperm_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0, `op_ready` is 1 and `result` is 0.
- R2: `op_ready` equals the inverse of `busy`. When `op_valid` and `op_ready` are both high at a clock edge, `busy` is 1 in the following cycle.
- R3: Once an operation is accepted, `busy` stays high for exactly WIDTH consecutive cycles.
- R4: `done` is high for exactly one cycle, which is the first cycle after `busy` falls.
- R5: With `op_sel` = 0 (extract), the source bits at the mask-1 positions are packed in ascending order into the lowest result bits. All higher result bits are 0.
- R6: With `op_sel` = 1 (deposit), the lowest source bits are placed in ascending order at the mask-1 positions. All other result bits are 0.
- R7: With `op_sel[1]` = 1 (codes 2 and 3, centrifuge), the source bits at mask-1 positions fill the lowest result bits and the source bits at mask-0 positions fill the bits above them. Each group keeps its ascending order.
- R8: A `op_valid` raised while `busy` is high is ignored. It changes neither the timing nor the result of the operation in progress.
- R9: `result` is unchanged from the `done` cycle until the next operation is accepted.
- R10: A new operation may be accepted in the `done` cycle. It then runs with the same timing as an operation started from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | High when the unit can accept an operation |
| op_sel | input | 2 | 0 selects extract, 1 selects deposit, 2 or 3 selects centrifuge |
| src | input | 64 | Source word |
| mask | input | 64 | Mask word |
| busy | output | 1 | Stall signal for the issuing stage |
| done | output | 1 | One-cycle completion strobe |
| result | output | 64 | Permuted word |

## Verification
Each operation is run with the following masks:
- An all-zero mask and an all-ones mask. These separate the zero-fill paths from the pass-through paths.
- A contiguous field. This shows whether a packed group lands at the correct offset.
- The alternating masks 0xAAAA… and 0x5555…. These expose off-by-one errors in the pointers.
- Random masks. These mix both kinds of bit.

Short hand-computed cases are also checked, for example a nibble swap produced by centrifuge and a compact deposit. They catch errors that the behavioural model and the design could both make. Two further cases cover timing: an intruding request during a running operation, which must leave that operation untouched, and a request issued in the `done` cycle, which confirms back-to-back issue.

// File: rtl/bperm_pkg.sv
package bperm_pkg;

  typedef enum logic [1:0] {
    OP_EXTRACT = 2'd0,
    OP_DEPOSIT = 2'd1,
    OP_CFUGE   = 2'd2
  } bperm_op_e;

  // Codes 2 and 3 both select centrifuge
  function automatic bperm_op_e bperm_decode(input logic [1:0] sel);
    if (sel[1])      return OP_CFUGE;
    else if (sel[0]) return OP_DEPOSIT;
    else             return OP_EXTRACT;
  endfunction

endpackage

// File: rtl/bperm_popcnt.sv
module bperm_popcnt #(
  parameter int W  = 64,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) cnt = cnt + CW'(vec[i]);
  end
endmodule

// File: rtl/bperm_seq.sv
module bperm_seq #(
  parameter int W  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(W - 1);

  logic          busy_q, done_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign idx  = idx_q;
endmodule

// File: rtl/bperm_lane.sv
module bperm_lane
  import bperm_pkg::*;
#(
  parameter int W  = 64,
  localparam int IW = $clog2(W),
  localparam int PW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  bperm_op_e     op_in,
  input  logic [W-1:0]  src_in,
  input  logic [W-1:0]  mask_in,
  input  logic [PW-1:0] ones_in,
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  result
);
  bperm_op_e     op_q;
  logic [W-1:0]  src_q, mask_q, res_q;
  logic [PW-1:0] lo_q, hi_q;
  logic          cur_bit, sel_bit;

  assign sel_bit = mask_q[0];
  assign cur_bit = src_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_EXTRACT;
      src_q  <= '0;
      mask_q <= '0;
      res_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (load) begin
      op_q   <= op_in;
      src_q  <= src_in;
      mask_q <= mask_in;
      res_q  <= '0;
      lo_q   <= '0;
      hi_q   <= ones_in;   // mask-0 bits start above all mask-1 bits
    end else if (step) begin
      mask_q <= mask_q >> 1;
      case (op_q)
        OP_DEPOSIT: begin
          // Source advances only when a mask-1 slot consumes a bit
          if (sel_bit) begin
            res_q[idx] <= cur_bit;
            src_q      <= src_q >> 1;
          end
        end
        OP_EXTRACT: begin
          src_q <= src_q >> 1;
          if (sel_bit) begin
            res_q[lo_q[IW-1:0]] <= cur_bit;
            lo_q <= lo_q + PW'(1);
          end
        end
        default: begin
          src_q <= src_q >> 1;
          if (sel_bit) begin
            res_q[lo_q[IW-1:0]] <= cur_bit;
            lo_q <= lo_q + PW'(1);
          end else begin
            res_q[hi_q[IW-1:0]] <= cur_bit;
            hi_q <= hi_q + PW'(1);
          end
        end
      endcase
    end
  end

  assign result = res_q;
endmodule

// File: rtl/bperm_unit.sv
module bperm_unit
  import bperm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  output logic         op_ready,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] src,
  input  logic [W-1:0] mask,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int IW = $clog2(W);
  localparam int PW = $clog2(W) + 1;

  logic          accept, busy_w;
  logic [IW-1:0] idx_w;
  logic [PW-1:0] ones_w;

  assign op_ready = ~busy_w;
  assign accept   = op_valid & ~busy_w;
  assign busy     = busy_w;

  bperm_popcnt #(.W(W)) u_pop (
    .vec (mask),
    .cnt (ones_w)
  );

  bperm_seq #(.W(W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .busy  (busy_w),
    .done  (done),
    .idx   (idx_w)
  );

  bperm_lane #(.W(W)) u_lane (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step    (busy_w),
    .op_in   (bperm_decode(op_sel)),
    .src_in  (src),
    .mask_in (mask),
    .ones_in (ones_w),
    .idx     (idx_w),
    .result  (result)
  );
endmodule

// File: rtl/bperm_unit_chk.sv
module bperm_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic         op_ready,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result
);
  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_ready |=> busy);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == W);

  p_busy_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < W);

  p_done_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_valid |=> (run_cnt == $past(run_cnt) + 1) || done);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && !$past(op_valid && op_ready) |-> $stable(result));
endmodule

bind bperm_unit bperm_unit_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/bperm_unit_bench.sv
`timescale 1ns/1ps
module bperm_unit_bench;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [1:0]   op_sel = 2'd0;
  logic [W-1:0] src = '0;
  logic [W-1:0] mask = '0;
  logic         busy, done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  bperm_unit #(.W(W)) u_bperm_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_sel(op_sel), .src(src), .mask(mask), .busy(busy), .done(done),
    .result(result)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [W-1:0] ref_perm(input logic [1:0] sel,
                                            input logic [W-1:0] s,
                                            input logic [W-1:0] m);
    logic [W-1:0] r;
    int k;
    r = '0;
    k = 0;
    if (sel == 2'd0) begin
      for (int i = 0; i < W; i++) if (m[i]) begin r[k] = s[i]; k++; end
    end else if (sel == 2'd1) begin
      for (int i = 0; i < W; i++) if (m[i]) begin r[i] = s[k]; k++; end
    end else begin
      for (int i = 0; i < W; i++) if (m[i]) begin r[k] = s[i]; k++; end
      for (int i = 0; i < W; i++) if (!m[i]) begin r[k] = s[i]; k++; end
    end
    return r;
  endfunction

  logic         ref_busy, ref_done, ref_hold;
  int           ref_cnt;
  logic [W-1:0] ref_res, ref_pend;
  logic [1:0]   ref_op;

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_busy <= 1'b0; ref_done <= 1'b0; ref_hold <= 1'b1;
      ref_cnt <= 0; ref_res <= '0; ref_pend <= '0; ref_op <= 2'd0;
    end else begin
      ref_done <= 1'b0;
      if (!ref_busy && op_valid) begin
        ref_busy <= 1'b1; ref_cnt <= 1; ref_hold <= 1'b0;
        ref_pend <= ref_perm(op_sel, src, mask); ref_op <= op_sel;
      end else if (ref_busy) begin
        if (ref_cnt == W) begin
          ref_busy <= 1'b0; ref_done <= 1'b1;
          ref_res <= ref_pend; ref_hold <= 1'b1;
        end else ref_cnt <= ref_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 op_ready", W'(op_ready), W'(!ref_busy));
      chk("R3 busy", W'(busy), W'(ref_busy));
      chk("R4 done", W'(done), W'(ref_done));
      if (ref_hold) chk("R9 result hold", result, ref_res);
      if (ref_done) begin
        if (ref_op == 2'd0)      chk("R5 extract", result, ref_res);
        else if (ref_op == 2'd1) chk("R6 deposit", result, ref_res);
        else                     chk("R7 centrifuge", result, ref_res);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic issue(input logic [1:0] sel, input logic [W-1:0] s, input logic [W-1:0] m);
    @(negedge clk);
    op_valid = 1'b1; op_sel = sel; src = s; mask = m;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 200; n++) begin
      if (done) return;
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [1:0] sel, input logic [W-1:0] s, input logic [W-1:0] m,
                     input logic [W-1:0] exp, input string req);
    issue(sel, s, m);
    wait_done();
    chk(req, result, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", W'(busy), '0);
    chk("R1 done", W'(done), '0);
    chk("R1 op_ready", W'(op_ready), W'(1));
    chk("R1 result", result, '0);

    // directed, hand-computed
    run(2'd0, 64'h0000_0000_0000_FF00, 64'h0000_0000_0000_0FF0, 64'h0000_0000_0000_00F0, "R5 field extract");
    run(2'd1, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0050, "R6 field deposit");
    run(2'd2, 64'h0000_0000_0000_00A5, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_005A, "R7 nibble swap");
    run(2'd3, 64'h0000_0000_0000_00A5, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_005A, "R7 code 3 centrifuge");
    run(2'd0, 64'h1234_5678_9ABC_DEF0, '1, 64'h1234_5678_9ABC_DEF0, "R5 full mask");
    run(2'd0, 64'h1234_5678_9ABC_DEF0, '0, '0, "R5 empty mask");
    run(2'd1, 64'h1234_5678_9ABC_DEF0, '0, '0, "R6 empty mask");
    run(2'd2, 64'h1234_5678_9ABC_DEF0, '0, 64'h1234_5678_9ABC_DEF0, "R7 empty mask");
    run(2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, "R6 alternating");

    // R9: result held over idle cycles
    repeat (5) @(negedge clk);
    chk("R9 idle hold", result, 64'hAAAA_AAAA_AAAA_AAAA);

    // R8: intruding request during busy is dropped
    issue(2'd0, 64'h0000_0000_0000_FF00, 64'h0000_0000_0000_0FF0);
    repeat (10) @(negedge clk);
    op_valid = 1'b1; op_sel = 2'd1; src = '1; mask = '1;
    repeat (3) @(negedge clk);
    op_valid = 1'b0;
    wait_done();
    chk("R8 ignored start", result, 64'h0000_0000_0000_00F0);

    // R10: back-to-back issue in the done cycle
    issue(2'd2, 64'h0000_0000_0000_00A5, 64'h0000_0000_0000_00F0);
    wait_done();
    op_valid = 1'b1; op_sel = 2'd0; src = 64'h8000_0000_0000_0001; mask = 64'h8000_0000_0000_0001;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R10 busy after done-cycle issue", W'(busy), W'(1));
    wait_done();
    chk("R10 second result", result, 64'h0000_0000_0000_0003);

    // patterned and random masks, checked by the model
    for (int n = 0; n < 12; n++) begin
      logic [W-1:0] s, m;
      s = {$urandom, $urandom};
      case (n % 4)
        0: m = 64'h5555_5555_5555_5555;
        1: m = 64'h00FF_0000_0000_FF00;
        2: m = {$urandom, $urandom} & {$urandom, $urandom};
        default: m = {$urandom, $urandom};
      endcase
      issue(2'(n % 3), s, m);
      wait_done();
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule